// File: doc/BRIEF.md
# Next-Free Entry Locator with Cascaded Full Chain

This block tracks which entries of a large associative array are unoccupied and keeps, in a register, the address of the unoccupied entry with the lowest index. Array operations that address "the next free entry" use that register instead of an explicit address. The array storage is not part of the block. Only the per-entry empty bits are modelled, together with the strobes that mark an entry empty or occupied.

Several devices can be cascaded through an active-low full chain. Each device receives a full-in from its upstream neighbour and drives a full-out to its downstream neighbour. The device that owns the system-wide next-free slot is the one whose full-in is low and whose own full-out is still high. Only that device accepts writes to the next-free slot.

Reads of the next-free register work in one of two ways. In chain mode (chain-enable low), only the owning device drives its value. In targeted mode (chain-enable high), the device whose device-select value equals its page address drives its value.

Top module: `nfl_locator`

## Requirements
- R1: Synchronous reset marks every entry empty, clears the next-free address to 0 and drops the local full flag.
- R2: The next-free address is the lowest-index empty entry. It changes on the clock edge that follows the edge that changed an empty bit, so it appears two edges after the strobe is sampled.
- R3: `set_empty` marks entry `entry_addr` empty and `clr_empty` marks it occupied. If both are asserted for the same entry in one cycle, the entry ends up occupied.
- R4: `full_out_n` is low exactly when `full_in_n` is low and `local_full` is high. It follows `full_in_n` combinationally.
- R5: `nf_accept` is high only when `full_in_n` is low, `full_out_n` is high and no empty bit changed on the previous edge. A `wr_nf` pulse while `nf_accept` is high marks the entry at the next-free address occupied. A `wr_nf` pulse while `nf_accept` is low is ignored.
- R6: When no entry is empty, `local_full` is high and the next-free address keeps its last value.
- R7: During a read (`rd_nf` high) with `chain_en_n` low, `rd_drive` is high exactly when `full_in_n` is low and `full_out_n` is high. While driving, `rd_data` carries the next-free address zero-extended to 16 bits.
- R8: During a read with `chain_en_n` high, `rd_drive` is high exactly when `dev_sel` equals `page_addr`, whatever the chain state.
- R9: While `rd_drive` is low, including whenever `rd_nf` is low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_empty | input | 1 | Mark entry `entry_addr` empty |
| clr_empty | input | 1 | Mark entry `entry_addr` occupied |
| entry_addr | input | clog2(DEPTH) | Entry addressed by the set/clear strobes |
| wr_nf | input | 1 | Occupy the entry at the next-free address (acted on only when accepted) |
| full_in_n | input | 1 | Active-low full from the upstream device |
| full_out_n | output | 1 | Active-low full to the downstream device |
| nf_accept | output | 1 | This device takes next-free writes now |
| rd_nf | input | 1 | Next-free read request |
| chain_en_n | input | 1 | Low: chain-arbitrated read; high: device-select read |
| page_addr | input | 16 | This device's page address |
| dev_sel | input | 16 | Device-select value |
| rd_drive | output | 1 | This device drives the read data |
| rd_data | output | 16 | Next-free address when driving, else 0 |
| nf_addr | output | clog2(DEPTH) | Registered next-free address |
| local_full | output | 1 | No empty entry in this device |

## Verification
The bench uses a 16-entry configuration. It sweeps single-entry holes across every index and fills the array in both directions, which catches an encoder that favours the highest index or that is off by one at the ends. It runs the array full to confirm that the pointer holds its value; a design that wrapped the pointer to 0 or dropped the flag would fail there. It pulses `wr_nf` on consecutive cycles to show that the stale pointer is never used twice, since a design without the pending gate would consume two entries. It also issues a same-cycle set/clear on one entry, where the wrong priority would leave the entry empty. Reads are checked in both modes against chain and select combinations, so a design that mixed up the two arbitration paths would drive when it should stay silent.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

    localparam int NF_DATA_W = 16;

    typedef enum logic {
        RD_CHAIN  = 1'b0,
        RD_TARGET = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic in_low;
        logic local_full;
        logic pending;
    } chain_view_t;

    function automatic logic chain_owner(chain_view_t v);
        return v.in_low && !v.local_full;
    endfunction

endpackage

// File: rtl/nfl_prio_enc.sv
module nfl_prio_enc #(
    parameter int N = 2048,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                idx = i[W-1:0];
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nfl_empty_store.sv
module nfl_empty_store #(
    parameter int N = 2048,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] addr,
    input  logic         take_en,
    input  logic [W-1:0] take_addr,
    output logic [N-1:0] bits,
    output logic         pending
);
    logic [N-1:0] nxt;

    // later assignments win: any clear overrides a set on the same entry
    always_comb begin
        nxt = bits;
        if (set_en)  nxt[addr]      = 1'b1;
        if (clr_en)  nxt[addr]      = 1'b0;
        if (take_en) nxt[take_addr] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits    <= '1;
            pending <= 1'b0;
        end else begin
            bits    <= nxt;
            pending <= set_en | clr_en | take_en;
        end
    end
endmodule

// File: rtl/nfl_chain_port.sv
module nfl_chain_port
    import nfl_pkg::*;
#(
    parameter int W  = 11,
    parameter int DW = NF_DATA_W
) (
    input  logic          full_in_n,
    input  logic          local_full,
    input  logic          pending,
    input  logic          rd_nf,
    input  logic          chain_en_n,
    input  logic [DW-1:0] page_addr,
    input  logic [DW-1:0] dev_sel,
    input  logic [W-1:0]  nf,
    output logic          full_out_n,
    output logic          accept,
    output logic          rd_drive,
    output logic [DW-1:0] rd_data
);
    chain_view_t view;
    rd_mode_e    mode;
    logic        owner;
    logic [DW-1:0] ext;

    always_comb begin
        view.in_low     = !full_in_n;
        view.local_full = local_full;
        view.pending    = pending;
        owner           = chain_owner(view);
        full_out_n      = !(view.in_low && local_full);
        accept          = owner && !view.pending;
        mode            = rd_mode_e'(chain_en_n);
        ext             = '0;
        ext[W-1:0]      = nf;
        case (mode)
            RD_CHAIN:  rd_drive = rd_nf && owner;
            default:   rd_drive = rd_nf && (dev_sel == page_addr);
        endcase
        rd_data = rd_drive ? ext : '0;
    end
endmodule

// File: rtl/nfl_locator.sv
module nfl_locator
    import nfl_pkg::*;
#(
    parameter  int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_empty,
    input  logic                 clr_empty,
    input  logic [ADDR_W-1:0]    entry_addr,
    input  logic                 wr_nf,
    input  logic                 full_in_n,
    output logic                 full_out_n,
    output logic                 nf_accept,
    input  logic                 rd_nf,
    input  logic                 chain_en_n,
    input  logic [NF_DATA_W-1:0] page_addr,
    input  logic [NF_DATA_W-1:0] dev_sel,
    output logic                 rd_drive,
    output logic [NF_DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0]    nf_addr,
    output logic                 local_full
);
    logic [DEPTH-1:0]  empty_bits;
    logic              upd_pending;
    logic [ADDR_W-1:0] enc_idx;
    logic              enc_any;
    logic [ADDR_W-1:0] nf_q;
    logic              full_q;

    nfl_empty_store #(.N(DEPTH), .W(ADDR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .set_en    (set_empty),
        .clr_en    (clr_empty),
        .addr      (entry_addr),
        .take_en   (wr_nf && nf_accept),
        .take_addr (nf_q),
        .bits      (empty_bits),
        .pending   (upd_pending)
    );

    nfl_prio_enc #(.N(DEPTH), .W(ADDR_W)) u_enc (
        .bits (empty_bits),
        .idx  (enc_idx),
        .any  (enc_any)
    );

    // pointer register: follows the encoder one clock behind the empty bits
    always_ff @(posedge clk) begin
        if (rst) begin
            nf_q   <= '0;
            full_q <= 1'b0;
        end else begin
            full_q <= !enc_any;
            if (enc_any) nf_q <= enc_idx;
        end
    end

    nfl_chain_port #(.W(ADDR_W), .DW(NF_DATA_W)) u_port (
        .full_in_n  (full_in_n),
        .local_full (full_q),
        .pending    (upd_pending),
        .rd_nf      (rd_nf),
        .chain_en_n (chain_en_n),
        .page_addr  (page_addr),
        .dev_sel    (dev_sel),
        .nf         (nf_q),
        .full_out_n (full_out_n),
        .accept     (nf_accept),
        .rd_drive   (rd_drive),
        .rd_data    (rd_data)
    );

    assign nf_addr    = nf_q;
    assign local_full = full_q;
endmodule

// File: rtl/nfl_locator_chk.sv
module nfl_locator_chk #(
    parameter  int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              full_in_n,
    input logic              full_out_n,
    input logic              nf_accept,
    input logic              rd_nf,
    input logic              chain_en_n,
    input logic [15:0]       page_addr,
    input logic [15:0]       dev_sel,
    input logic              rd_drive,
    input logic [15:0]       rd_data,
    input logic [ADDR_W-1:0] nf_addr,
    input logic              local_full,
    input logic [DEPTH-1:0]  empty_bits,
    input logic              upd_pending
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (nf_addr == '0 && !local_full && empty_bits == '1));

    // R2
    a_r2_points_empty: assert property (@(posedge clk) disable iff (rst)
        (!local_full && !upd_pending) |-> empty_bits[nf_addr]);

    // R4
    a_r4_high_passes: assert property (@(posedge clk) disable iff (rst)
        full_in_n |-> full_out_n);
    a_r4_low_when_full: assert property (@(posedge clk) disable iff (rst)
        (!full_in_n && local_full) |-> !full_out_n);

    // R5
    a_r5_accept_owner: assert property (@(posedge clk) disable iff (rst)
        nf_accept |-> (!full_in_n && full_out_n && !upd_pending));

    // R6
    a_r6_full_means_none: assert property (@(posedge clk) disable iff (rst)
        (local_full && !upd_pending) |-> (empty_bits == '0));
    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (local_full && $past(local_full)) |-> $stable(nf_addr));

    // R7
    a_r7_chain_drive: assert property (@(posedge clk) disable iff (rst)
        (rd_drive && !chain_en_n) |-> (!full_in_n && full_out_n));

    // R8
    a_r8_target_miss: assert property (@(posedge clk) disable iff (rst)
        (rd_nf && chain_en_n && dev_sel != page_addr) |-> !rd_drive);

    // R9
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_nf |-> (!rd_drive && rd_data == '0));
endmodule

bind nfl_locator nfl_locator_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .full_in_n   (full_in_n),
    .full_out_n  (full_out_n),
    .nf_accept   (nf_accept),
    .rd_nf       (rd_nf),
    .chain_en_n  (chain_en_n),
    .page_addr   (page_addr),
    .dev_sel     (dev_sel),
    .rd_drive    (rd_drive),
    .rd_data     (rd_data),
    .nf_addr     (nf_addr),
    .local_full  (local_full),
    .empty_bits  (empty_bits),
    .upd_pending (upd_pending)
);

// File: tb/nfl_locator_test.sv
module nfl_locator_test;
    localparam int DEPTH  = 16;
    localparam int AW     = 4;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_empty = 1'b0, clr_empty = 1'b0, wr_nf = 1'b0;
    logic [AW-1:0] entry_addr = '0;
    logic          full_in_n = 1'b0;
    logic          full_out_n, nf_accept, rd_drive, local_full;
    logic          rd_nf = 1'b0, chain_en_n = 1'b0;
    logic [15:0]   page_addr = 16'h1234, dev_sel = 16'h0000;
    logic [15:0]   rd_data;
    logic [AW-1:0] nf_addr;

    int n_cmp = 0;
    int n_bad = 0;

    logic [DEPTH-1:0] mdl = '1;
    int               exp_nf = 0;
    logic             exp_full = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nfl_locator #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .set_empty(set_empty), .clr_empty(clr_empty),
        .entry_addr(entry_addr), .wr_nf(wr_nf), .full_in_n(full_in_n),
        .full_out_n(full_out_n), .nf_accept(nf_accept), .rd_nf(rd_nf),
        .chain_en_n(chain_en_n), .page_addr(page_addr), .dev_sel(dev_sel),
        .rd_drive(rd_drive), .rd_data(rd_data), .nf_addr(nf_addr),
        .local_full(local_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void recompute();
        logic found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mdl[i] && !found) begin
                found  = 1'b1;
                exp_nf = i;
            end
        end
        exp_full = !found;
    endfunction

    // called at a falling edge; returns at the falling edge after the pointer update
    task automatic op(input logic s, input logic c, input logic w, input int a);
        logic acc;
        acc        = !full_in_n && !exp_full;
        set_empty  = s;
        clr_empty  = c;
        wr_nf      = w;
        entry_addr = a[AW-1:0];
        if (s) mdl[a] = 1'b1;
        if (c) mdl[a] = 1'b0;
        if (w && acc) mdl[exp_nf] = 1'b0;
        @(negedge clk);
        set_empty = 1'b0;
        clr_empty = 1'b0;
        wr_nf     = 1'b0;
        @(negedge clk);
        recompute();
    endtask

    task automatic chk_state(input string req);
        chk({req, " nf"}, int'(nf_addr), exp_nf);
        chk({req, " full"}, int'(local_full), int'(exp_full));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 nf", int'(nf_addr), 0);
        chk("R1 full", int'(local_full), 0);
        chk("R4 out after reset", int'(full_out_n), 1);
        chk("R5 accept after reset", int'(nf_accept), 1);
        chk("R9 idle drive", int'(rd_drive), 0);
        chk("R9 idle data", int'(rd_data), 0);

        // R2/R6: fill ascending by clear strobes
        for (int k = 0; k < DEPTH; k++) begin
            op(1'b0, 1'b1, 1'b0, k);
            chk_state("R2 fill-up");
        end
        chk("R6 hold last", int'(nf_addr), DEPTH - 1);
        chk("R4 full chain low", int'(full_out_n), 0);
        chk("R5 full no accept", int'(nf_accept), 0);
        full_in_n = 1'b1;
        #1;
        chk("R4 upstream high", int'(full_out_n), 1);
        full_in_n = 1'b0;

        // R2/R6: single hole at every index
        for (int k = 0; k < DEPTH; k++) begin
            op(1'b1, 1'b0, 1'b0, k);
            chk_state("R2 hole");
            op(1'b0, 1'b1, 1'b0, k);
            chk_state("R6 refull");
            chk("R6 hold at hole", int'(nf_addr), k);
        end

        // R3: set and clear together on an occupied entry leaves it occupied
        op(1'b1, 1'b1, 1'b0, 5);
        chk("R3 clear wins full", int'(local_full), 1);
        chk_state("R3");

        // R2: open entries descending, pointer follows lowest
        for (int k = DEPTH - 1; k >= 0; k--) begin
            op(1'b1, 1'b0, 1'b0, k);
            chk_state("R2 open-down");
        end
        // R3: set and clear together on an empty entry leaves it occupied
        op(1'b1, 1'b1, 1'b0, 0);
        chk("R3 clear wins empty", int'(nf_addr), 1);

        // R5: next-free writes consume entries in order
        op(1'b1, 1'b0, 1'b0, 0);
        for (int k = 0; k < DEPTH; k++) begin
            op(1'b0, 1'b0, 1'b1, 0);
            chk_state("R5 nf write");
        end
        chk("R5 full after writes", int'(local_full), 1);

        // R5: write ignored when upstream is not full
        op(1'b1, 1'b0, 1'b0, 3);
        op(1'b1, 1'b0, 1'b0, 9);
        full_in_n = 1'b1;
        #1;
        chk("R5 no accept upstream", int'(nf_accept), 0);
        op(1'b0, 1'b0, 1'b1, 0);
        chk("R5 ignored write", int'(nf_addr), 3);
        full_in_n = 1'b0;

        // R5: back-to-back write consumes exactly one entry
        wr_nf = 1'b1;
        @(negedge clk);
        chk("R5 gated while pending", int'(nf_accept), 0);
        @(negedge clk);
        wr_nf = 1'b0;
        chk("R5 accept again", int'(nf_accept), 1);
        chk("R5 single take", int'(nf_addr), 9);
        @(negedge clk);
        chk("R5 single take held", int'(nf_addr), 9);
        mdl[3] = 1'b0;
        recompute();

        // R7: chain-mode reads
        rd_nf = 1'b1;
        chain_en_n = 1'b0;
        #1;
        chk("R7 owner drives", int'(rd_drive), 1);
        chk("R7 owner data", int'(rd_data), 9);
        full_in_n = 1'b1;
        #1;
        chk("R7 upstream free quiet", int'(rd_drive), 0);
        chk("R9 quiet data", int'(rd_data), 0);
        // R8: targeted reads ignore chain state
        chain_en_n = 1'b1;
        dev_sel = 16'h1234;
        #1;
        chk("R8 match drives", int'(rd_drive), 1);
        chk("R8 match data", int'(rd_data), 9);
        dev_sel = 16'h1235;
        #1;
        chk("R8 miss quiet", int'(rd_drive), 0);
        chk("R9 miss data", int'(rd_data), 0);
        rd_nf = 1'b0;
        dev_sel = 16'h1234;
        #1;
        chk("R9 no request", int'(rd_drive), 0);
        full_in_n = 1'b0;
        chain_en_n = 1'b0;
        @(negedge clk);
        op(1'b0, 1'b1, 1'b0, 9);
        rd_nf = 1'b1;
        #1;
        chk("R7 full device quiet", int'(rd_drive), 0);
        rd_nf = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule